// File: doc/BRIEF.md
# Relocatable Peripheral Window Decoder

This block places a 4 KB window of on-chip peripherals anywhere in a 24-bit bus address space. Software sets the window position through a 16-bit base register. That register sits at a fixed location that can only be reached with the supervisor data function code. The base register can also require the bus function code to match a stored 3-bit code. The decoder looks at every bus cycle: address, function code, direction, byte strobes, and whether the bus is 8 or 16 bits wide. It then raises a select for the internal window.

The block also decodes its own two register locations and blocks external chip selects on them. It watches for an outside device that answers inside the window. When that happens it sets a sticky conflict flag, and it can also pulse a bus error. When no processor core drives the function-code pins, the decoder treats every cycle as supervisor data.

Top module: `periph_window_decoder`

## Requirements
- R1: After reset the base register reads 0xBFFF, the conflict flag and conflict enable are 0, and `winSel` stays low for every access until the window is configured (see R6).
- R2: The base register is word address 0x0F2 (byte 0x0F2 = bits 15:8, byte 0x0F3 = bits 7:0). The control register is word address 0x0F4 (byte 0x0F5 = bits 7:0, bit 1 conflict enable, bit 0 conflict flag; byte 0x0F4 reads 0). Both are selected only with effective function code 5. With any other code, a write leaves them unchanged and a read returns 0.
- R3: Base register bits 11:0 give address bits 23:12 of the window. A configured window matches exactly when `busAddr[23:12]` equals that field.
- R4: Base bit 12 is the compare enable. When it is 0 the function code is ignored. When it is 1 the effective function code must equal base bits 15:13.
- R5: A stored code of 7 is written and read back unchanged. An access with effective code 7 never selects the window.
- R6: In 16-bit mode (`busNarrow`=0), any write to the base register marks the window configured, so a word write takes effect on the next cycle. In 8-bit mode the window becomes configured only when byte 0x0F3 is written.
- R7: `csInhibit` is high on any valid cycle whose address lies in 0x0F2..0x0F5, whatever the function code.
- R8: A valid cycle that selects the window while `extAck` is high sets the conflict flag on the next clock. The flag stays set until a write to byte 0x0F5 with bit 0 = 1 clears it.
- R9: `busErr` is high in the same cycle as a conflicting access only when conflict enable is 1.
- R10: When `cpuPresent` is 0, the `busFc` pins are ignored and the effective function code is 5.
- R11: In 16-bit mode, `byteHi` and `byteLo` pick lanes 15:8 and 7:0 for both reads and writes. In 8-bit mode the data sits on lane 7:0, `busAddr[0]` picks the byte, and reads return 0 in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busValid | input | 1 | A bus cycle is present this clock |
| busAddr | input | 24 | Byte address |
| busFc | input | 3 | Function code from the core |
| cpuPresent | input | 1 | 1 = core drives busFc, 0 = treat as code 5 |
| busWrite | input | 1 | 1 = write, 0 = read |
| byteHi | input | 1 | Upper lane strobe (16-bit mode) |
| byteLo | input | 1 | Lower lane strobe (16-bit mode) |
| busNarrow | input | 1 | 1 = 8-bit data bus mode |
| wrData | input | 16 | Write data |
| extAck | input | 1 | An external device answered this cycle |
| winSel | output | 1 | Access falls in the peripheral window |
| csInhibit | output | 1 | Suppress external chip selects |
| rdData | output | 16 | Register read data |
| busErr | output | 1 | Bus error for a decode conflict |
| conflictFlag | output | 1 | Sticky conflict status |

## Verification
The window match is tested with addresses just inside and just outside both ends of the 4 KB range. This separates a correct compare on bits 23:12 from an off-by-one or a wrong bit slice. Each function code is tried with the compare enable both set and clear, so ignoring the code can be told apart from requiring it, and code 7 shows the interrupt-acknowledge exclusion. Byte-wise writes in 8-bit mode (high byte only, then low byte) are contrasted with high-only and full-word writes in 16-bit mode, which shows when the window is treated as configured. Conflicts are driven with the enable clear and set, and around write-1-to-clear control writes, so the sticky flag can be told apart from the single-cycle error.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int ADDR_W   = 24;
  localparam int WIN_BITS = 12;
  localparam int FC_W     = 3;
  localparam int REG_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int BASE_W   = ADDR_W - WIN_BITS;
  localparam int CMP_BIT  = BASE_W;
  localparam int FC_LSB   = BASE_W + 1;

  localparam logic [FC_W-1:0]   FC_SUPV_DATA  = 3'd5;
  localparam logic [FC_W-1:0]   FC_IACK       = 3'd7;
  localparam logic [ADDR_W-1:0] BASE_REG_ADDR = 24'h0000F2;
  localparam logic [ADDR_W-1:0] CTL_REG_ADDR  = 24'h0000F4;
  localparam logic [REG_W-1:0]  BASE_RESET    = 16'hBFFF;
  localparam int CTL_EN_BIT   = 1;
  localparam int CTL_STAT_BIT = 0;

  typedef struct packed {
    logic              baseWrHi;
    logic              baseWrLo;
    logic              markCfg;
    logic              ctlWr;
    logic              setStat;
    logic [BYTE_W-1:0] laneHi;
    logic [BYTE_W-1:0] laneLo;
  } pwdStrobe_t;
endpackage

// File: rtl/pwd_dpath.sv
module pwd_dpath
  import pwd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic [BASE_W-1:0]    winAddr,
  input  logic [FC_W-1:0]      effFc,
  input  pwdStrobe_t           strb,
  output logic                 winHit,
  output logic [REG_W-1:0]     baseWord,
  output logic [REG_W-1:0]     ctlWord,
  output logic                 conflictEn,
  output logic                 conflictStat
);
  logic [REG_W-1:0] baseReg;
  logic             cfgDone;
  logic             enReg;
  logic             statReg;
  logic             fcOk;
  logic             statClr;

  assign statClr = strb.ctlWr && strb.laneLo[CTL_STAT_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= BASE_RESET;
      cfgDone <= 1'b0;
      enReg   <= 1'b0;
      statReg <= 1'b0;
    end else begin
      if (strb.baseWrHi) baseReg[REG_W-1:BYTE_W] <= strb.laneHi;
      if (strb.baseWrLo) baseReg[BYTE_W-1:0]     <= strb.laneLo;
      if (strb.markCfg)  cfgDone <= 1'b1;
      if (strb.ctlWr)    enReg   <= strb.laneLo[CTL_EN_BIT];
      if (strb.setStat)  statReg <= 1'b1;
      else if (statClr)  statReg <= 1'b0;
    end
  end

  always_comb begin
    fcOk = !baseReg[CMP_BIT] || (effFc == baseReg[REG_W-1:FC_LSB]);
    winHit = busValid && cfgDone && (effFc != FC_IACK) && fcOk
             && (winAddr == baseReg[BASE_W-1:0]);
  end

  assign baseWord = baseReg;
  always_comb begin
    ctlWord = '0;
    ctlWord[CTL_EN_BIT]   = enReg;
    ctlWord[CTL_STAT_BIT] = statReg;
  end
  assign conflictEn   = enReg;
  assign conflictStat = statReg;

  // R8: flag holds until a write-1 clear
  a_r8_stat_sticky: assert property (@(posedge clk) disable iff (!rstN)
    statReg && !statClr |=> statReg);
  // R8: a conflict always lands in the flag
  a_r8_stat_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStat |=> statReg);
  // R6: configured state only comes from a marking write
  a_r6_cfg_source: assert property (@(posedge clk) disable iff (!rstN)
    !cfgDone && !strb.markCfg |=> !cfgDone);
endmodule

// File: rtl/pwd_ctrl.sv
module pwd_ctrl
  import pwd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [FC_W-1:0]      busFc,
  input  logic                 cpuPresent,
  input  logic                 busWrite,
  input  logic                 byteHi,
  input  logic                 byteLo,
  input  logic                 busNarrow,
  input  logic [REG_W-1:0]     wrData,
  input  logic                 extAck,
  input  logic                 winHit,
  input  logic [REG_W-1:0]     baseWord,
  input  logic [REG_W-1:0]     ctlWord,
  input  logic                 conflictEn,
  output logic [FC_W-1:0]      effFc,
  output pwdStrobe_t           strb,
  output logic                 csInhibit,
  output logic [REG_W-1:0]     rdData,
  output logic                 busErr
);
  logic             supv;
  logic             baseSel;
  logic             ctlSel;
  logic             hiOn;
  logic             loOn;
  logic             doWr;
  logic             doRd;
  logic [REG_W-1:0] selWord;

  always_comb begin
    effFc   = cpuPresent ? busFc : FC_SUPV_DATA;
    supv    = busValid && (effFc == FC_SUPV_DATA);
    baseSel = supv && (busAddr[ADDR_W-1:1] == BASE_REG_ADDR[ADDR_W-1:1]);
    ctlSel  = supv && (busAddr[ADDR_W-1:1] == CTL_REG_ADDR[ADDR_W-1:1]);
    csInhibit = busValid && (busAddr >= BASE_REG_ADDR)
                && (busAddr <= CTL_REG_ADDR + 24'd1);
    hiOn    = busNarrow ? !busAddr[0] : byteHi;
    loOn    = busNarrow ?  busAddr[0] : byteLo;
    doWr    = busValid && busWrite;
    doRd    = busValid && !busWrite;
  end

  always_comb begin
    strb.laneHi   = busNarrow ? wrData[BYTE_W-1:0] : wrData[REG_W-1:BYTE_W];
    strb.laneLo   = wrData[BYTE_W-1:0];
    strb.baseWrHi = doWr && baseSel && hiOn;
    strb.baseWrLo = doWr && baseSel && loOn;
    strb.markCfg  = doWr && baseSel && (busNarrow ? loOn : (hiOn || loOn));
    strb.ctlWr    = doWr && ctlSel && loOn;
    strb.setStat  = busValid && winHit && extAck;
  end

  always_comb begin
    selWord = baseSel ? baseWord : (ctlSel ? ctlWord : '0);
    rdData  = '0;
    if (doRd && (baseSel || ctlSel)) begin
      if (busNarrow) begin
        rdData[BYTE_W-1:0] = busAddr[0] ? selWord[BYTE_W-1:0]
                                        : selWord[REG_W-1:BYTE_W];
      end else begin
        if (hiOn) rdData[REG_W-1:BYTE_W] = selWord[REG_W-1:BYTE_W];
        if (loOn) rdData[BYTE_W-1:0]     = selWord[BYTE_W-1:0];
      end
    end
  end

  assign busErr = strb.setStat && conflictEn;

  // R9: error only with reporting enabled
  a_r9_err_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> conflictEn);
  // R5: interrupt-acknowledge cycles never reach the window
  a_r5_no_iack: assert property (@(posedge clk) disable iff (!rstN)
    busValid && (effFc == FC_IACK) |-> !winHit);
  // R7: own registers always hide external selects
  a_r7_regs_hide_cs: assert property (@(posedge clk) disable iff (!rstN)
    (baseSel || ctlSel) |-> csInhibit);
  // R2: non-supervisor cycles cannot write the registers
  a_r2_user_no_write: assert property (@(posedge clk) disable iff (!rstN)
    busValid && (effFc != FC_SUPV_DATA)
      |-> !(strb.baseWrHi || strb.baseWrLo || strb.ctlWr));
  // R10: missing core means supervisor data code
  a_r10_forced_fc: assert property (@(posedge clk) disable iff (!rstN)
    !cpuPresent |-> effFc == FC_SUPV_DATA);
endmodule

// File: rtl/periph_window_decoder.sv
module periph_window_decoder
  import pwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic [23:0]       busAddr,
  input  logic [2:0]        busFc,
  input  logic              cpuPresent,
  input  logic              busWrite,
  input  logic              byteHi,
  input  logic              byteLo,
  input  logic              busNarrow,
  input  logic [15:0]       wrData,
  input  logic              extAck,
  output logic              winSel,
  output logic              csInhibit,
  output logic [15:0]       rdData,
  output logic              busErr,
  output logic              conflictFlag
);
  pwdStrobe_t       strb;
  logic [FC_W-1:0]  effFc;
  logic             winHit;
  logic [REG_W-1:0] baseWord;
  logic [REG_W-1:0] ctlWord;
  logic             conflictEn;

  pwd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
    .busFc(busFc), .cpuPresent(cpuPresent), .busWrite(busWrite),
    .byteHi(byteHi), .byteLo(byteLo), .busNarrow(busNarrow),
    .wrData(wrData), .extAck(extAck), .winHit(winHit),
    .baseWord(baseWord), .ctlWord(ctlWord), .conflictEn(conflictEn),
    .effFc(effFc), .strb(strb), .csInhibit(csInhibit),
    .rdData(rdData), .busErr(busErr)
  );

  pwd_dpath dpath_i (
    .clk(clk), .rstN(rstN), .busValid(busValid),
    .winAddr(busAddr[ADDR_W-1:WIN_BITS]), .effFc(effFc), .strb(strb),
    .winHit(winHit), .baseWord(baseWord), .ctlWord(ctlWord),
    .conflictEn(conflictEn), .conflictStat(conflictFlag)
  );

  assign winSel = winHit;
endmodule

// File: tb/periph_window_decoder_tb.sv
module periph_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic [23:0] busAddr = '0;
  logic [2:0]  busFc = '0;
  logic        cpuPresent = 1'b1;
  logic        busWrite = 1'b0;
  logic        byteHi = 1'b0;
  logic        byteLo = 1'b0;
  logic        busNarrow = 1'b0;
  logic [15:0] wrData = '0;
  logic        extAck = 1'b0;
  logic        winSel, csInhibit, busErr, conflictFlag;
  logic [15:0] rdData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  logic [15:0] mBase;
  bit mCfg, mEn, mStat;

  always #5 clk = ~clk;

  periph_window_decoder dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
    .busFc(busFc), .cpuPresent(cpuPresent), .busWrite(busWrite),
    .byteHi(byteHi), .byteLo(byteLo), .busNarrow(busNarrow),
    .wrData(wrData), .extAck(extAck), .winSel(winSel),
    .csInhibit(csInhibit), .rdData(rdData), .busErr(busErr),
    .conflictFlag(conflictFlag)
  );

  task automatic modelReset();
    mBase = 16'hBFFF; mCfg = 0; mEn = 0; mStat = 0;
  endtask

  task automatic doReset();
    busValid = 0;
    rstN = 0;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic cyc(input string req, input bit v, input logic [23:0] a,
                     input logic [2:0] fc, input bit w, input bit hi,
                     input bit lo, input logic [15:0] d, input bit ext);
    int eFc, word, expRd, top, lanel, laneh;
    bit bSel, cSel, hit, cs, eErr, hOn, lOn, clr;
    busValid = v; busAddr = a; busFc = fc; busWrite = w;
    byteHi = hi; byteLo = lo; wrData = d; extAck = ext;
    #4;
    eFc  = cpuPresent ? int'(fc) : 5;
    bSel = v && eFc == 5 && (int'(a) / 2) == (242 / 2);
    cSel = v && eFc == 5 && (int'(a) / 2) == (244 / 2);
    hit  = v && mCfg && eFc != 7 && (int'(a) / 4096) == (int'(mBase) % 4096)
           && (((int'(mBase) / 4096) % 2) == 0 || eFc == int'(mBase) / 8192);
    cs   = v && int'(a) >= 242 && int'(a) <= 245;
    word = bSel ? int'(mBase) : (cSel ? (int'(mEn) * 2 + int'(mStat)) : 0);
    hOn  = busNarrow ? (a[0] == 1'b0) : hi;
    lOn  = busNarrow ? (a[0] == 1'b1) : lo;
    expRd = 0;
    if (v && !w && (bSel || cSel)) begin
      if (busNarrow) expRd = a[0] ? word % 256 : word / 256;
      else expRd = (hOn ? (word / 256) * 256 : 0) + (lOn ? word % 256 : 0);
    end
    eErr = hit && ext && mEn;
    checks++;
    if (winSel !== hit || csInhibit !== cs || rdData !== 16'(expRd) ||
        busErr !== eErr || conflictFlag !== mStat) begin
      fails++;
      $display("FAIL %s addr=%h: actual sel=%b cs=%b rd=%h err=%b flag=%b expected sel=%b cs=%b rd=%h err=%b flag=%b",
               req, a, winSel, csInhibit, rdData, busErr, conflictFlag,
               hit, cs, 16'(expRd), eErr, mStat);
    end
    @(posedge clk);
    laneh = busNarrow ? int'(d) % 256 : int'(d) / 256;
    lanel = int'(d) % 256;
    clr = 0;
    if (v && w && bSel) begin
      top = int'(mBase);
      if (hOn) top = laneh * 256 + top % 256;
      if (lOn) top = (top / 256) * 256 + lanel;
      mBase = 16'(top);
      if (busNarrow ? lOn : (hOn || lOn)) mCfg = 1;
    end
    if (v && w && cSel && lOn) begin
      mEn = (lanel / 2) % 2;
      clr = lanel % 2;
    end
    if (hit && ext) mStat = 1;
    else if (clr) mStat = 0;
    @(negedge clk);
  endtask

  task automatic idle(input string req);
    cyc(req, 0, 24'h0, 3'd0, 0, 0, 0, 16'h0, 0);
  endtask

  initial begin
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state and readback
    idle("R1");
    cyc("R1", 1, 24'h0000F2, 3'd5, 0, 1, 1, 16'h0, 0);
    cyc("R1", 1, 24'hFFF010, 3'd5, 0, 1, 1, 16'h0, 0);
    cyc("R1", 1, 24'h0000F4, 3'd5, 0, 1, 1, 16'h0, 0);
    // R2/R7: user space cannot reach the registers
    cyc("R2", 1, 24'h0000F2, 3'd1, 0, 1, 1, 16'h0, 0);
    cyc("R2", 1, 24'h0000F2, 3'd1, 1, 1, 1, 16'h0123, 0);
    cyc("R2", 1, 24'h0000F2, 3'd5, 0, 1, 1, 16'h0, 0);
    cyc("R7", 1, 24'h0000F5, 3'd2, 0, 0, 1, 16'h0, 0);
    cyc("R7", 1, 24'h0000F1, 3'd5, 0, 1, 1, 16'h0, 0);
    cyc("R7", 1, 24'h0000F6, 3'd5, 0, 1, 1, 16'h0, 0);
    // R6/R11: 8-bit mode, high byte first leaves window closed
    busNarrow = 1;
    cyc("R6", 1, 24'h0000F2, 3'd5, 1, 0, 0, 16'h0003, 0);
    cyc("R6", 1, 24'h3FF004, 3'd5, 0, 0, 0, 16'h0, 0);
    cyc("R11", 1, 24'h0000F2, 3'd5, 0, 0, 0, 16'h0, 0);
    cyc("R6", 1, 24'h0000F3, 3'd5, 1, 0, 0, 16'hAA45, 0);
    cyc("R11", 1, 24'h0000F3, 3'd5, 0, 0, 0, 16'h0, 0);
    // R3/R4: compare off, any code matches, edges of window
    cyc("R3", 1, 24'h345000, 3'd1, 0, 0, 0, 16'h0, 0);
    cyc("R3", 1, 24'h345FFF, 3'd6, 0, 0, 0, 16'h0, 0);
    cyc("R3", 1, 24'h344FFF, 3'd1, 0, 0, 0, 16'h0, 0);
    cyc("R3", 1, 24'h346000, 3'd1, 0, 0, 0, 16'h0, 0);
    cyc("R4", 1, 24'h345100, 3'd2, 0, 0, 0, 16'h0, 0);
    cyc("R5", 1, 24'h345100, 3'd7, 0, 0, 0, 16'h0, 0);
    // R6: 16-bit mode, high-only write configures
    busNarrow = 0;
    doReset();
    cyc("R6", 1, 24'h0000F2, 3'd5, 1, 1, 0, 16'h00AA, 0);
    cyc("R6", 1, 24'h0FF800, 3'd3, 0, 0, 0, 16'h0, 0);
    cyc("R11", 1, 24'h0000F2, 3'd5, 0, 1, 0, 16'h0, 0);
    doReset();
    cyc("R6", 1, 24'h0000F2, 3'd5, 1, 1, 1, 16'hB345, 0);
    cyc("R6", 1, 24'h345010, 3'd5, 0, 0, 0, 16'h0, 0);
    for (int f = 0; f < 8; f++)
      cyc("R4", 1, 24'h345020, 3'(f), 0, 0, 0, 16'h0, 0);
    cyc("R11", 1, 24'h0000F2, 3'd5, 0, 0, 1, 16'h0, 0);
    // R5: code 7 stored and never matched
    cyc("R5", 1, 24'h0000F2, 3'd5, 1, 1, 1, 16'hF345, 0);
    cyc("R5", 1, 24'h0000F2, 3'd5, 0, 1, 1, 16'h0, 0);
    for (int f = 0; f < 8; f++)
      cyc("R5", 1, 24'h345020, 3'(f), 0, 0, 0, 16'h0, 0);
    // R10: no core, pins ignored
    cyc("R10", 1, 24'h0000F2, 3'd5, 1, 1, 1, 16'hB345, 0);
    cpuPresent = 0;
    cyc("R10", 1, 24'h345040, 3'd2, 0, 0, 0, 16'h0, 0);
    cyc("R10", 1, 24'h0000F2, 3'd0, 0, 1, 1, 16'h0, 0);
    cpuPresent = 1;
    cyc("R10", 1, 24'h345040, 3'd2, 0, 0, 0, 16'h0, 0);
    // R8/R9: conflicts
    cyc("R8", 1, 24'h0000F2, 3'd5, 1, 1, 1, 16'h0345, 0);
    cyc("R9", 1, 24'h345010, 3'd3, 0, 0, 0, 16'h0, 1);
    cyc("R8", 1, 24'h0000F4, 3'd5, 0, 1, 1, 16'h0, 0);
    cyc("R8", 1, 24'h0000F5, 3'd5, 1, 0, 1, 16'h0002, 0);
    cyc("R9", 1, 24'h345010, 3'd3, 0, 0, 0, 16'h0, 1);
    cyc("R9", 1, 24'h355010, 3'd3, 0, 0, 0, 16'h0, 1);
    cyc("R8", 1, 24'h0000F5, 3'd5, 1, 0, 1, 16'h0003, 0);
    cyc("R8", 1, 24'h0000F4, 3'd5, 0, 1, 1, 16'h0, 0);
    cyc("R9", 1, 24'h345FFE, 3'd0, 0, 0, 0, 16'h0, 1);
    cyc("R8", 1, 24'h0000F4, 3'd5, 1, 1, 0, 16'hFFFF, 0);
    cyc("R8", 1, 24'h0000F5, 3'd1, 1, 0, 1, 16'h0001, 0);
    cyc("R8", 1, 24'h0000F5, 3'd5, 1, 0, 1, 16'h0000, 0);
    cyc("R9", 1, 24'h345010, 3'd3, 0, 0, 1, 16'h0, 1);
    idle("R8");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual no finish expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule